// File: doc/BRIEF.md
# Per-Core Soft Reset Sequencer

This block runs a software-requested warm reset on one core, on any chosen group of cores, or on all of them. The reset reaches only the core logic and, optionally, the vector/floating-point unit. The other reset domains (power-on reset, debug, shared cache and shared debug bus) are not among its outputs and are never driven. Debug state, breakpoints and watchpoints therefore survive. For each core the sequencer waits until that core reports standby-idle, then drives its core-only reset low. After five cycles in reset it lets go of the core's power clamps. The reset is held for at least sixteen cycles, and both resets return high in the same cycle.

Requests enter over a valid/ready handshake carrying a core mask and two mode bits. The requester must keep `req_valid` and the payload steady until `req_ready` is seen high at a clock edge. `req_ready` is high only while no core is in a sequence. A vector-only mode resets just the vector unit, with the same hold rules and no standby wait. If a core does not report idle within a programmable number of cycles, it is left alone and an error pulse is raised.

Top module: `soft_rst_seq`

## Requirements
- R1: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when every `busy` bit is low. A request waiting on low `req_ready` is taken at the first edge at which `req_ready` is high.
- R2: In core mode (`req_vec_only`=0), a masked core goes busy with `clamp_en` high and its resets high in the cycle after acceptance. Its `core_rst_n` goes low in the cycle after the first edge at which its `standby_idle` is sampled high.
- R3: If `standby_idle` stays low for `timeout_cycles` cycles of waiting (a value of 0 acts as 1), the core returns to idle without any reset, and its `err` bit is high for exactly one cycle.
- R4: `clamp_en` stays high during the first 5 cycles that `core_rst_n` is low and is low from the sixth cycle on.
- R5: `core_rst_n` stays low for exactly 16 consecutive cycles.
- R6: With `req_with_vec`=1 in core mode, `vec_rst_n` falls and rises in the same cycles as `core_rst_n`. With `req_with_vec`=0 it stays high.
- R7: In vector-only mode (`req_vec_only`=1), `vec_rst_n` is low for exactly 16 cycles starting the cycle after acceptance, regardless of `standby_idle`. In this mode `core_rst_n` stays high and `clamp_en` stays low.
- R8: `done` for a core is high for exactly one cycle: the first cycle in which its resets are back high after a completed sequence.
- R9: Cores whose mask bit is 0 keep their resets high and their `busy` low. A request with an all-zero mask is accepted and changes nothing.
- R10: While `rst_n` is low, all resets are high, `clamp_en`, `busy`, `done` and `err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (no core busy) |
| req_mask | input | NUM_CORES | Cores to reset |
| req_vec_only | input | 1 | 1 = vector-unit-only reset |
| req_with_vec | input | 1 | 1 = include vector reset in core mode |
| timeout_cycles | input | TMO_W | Standby wait limit in cycles |
| standby_idle | input | NUM_CORES | Per-core idle indication |
| core_rst_n | output | NUM_CORES | Per-core core-only reset, active low |
| vec_rst_n | output | NUM_CORES | Per-core vector-unit reset, active low |
| clamp_en | output | NUM_CORES | Per-core power clamp enable |
| busy | output | NUM_CORES | Core in a sequence |
| done | output | NUM_CORES | One-cycle completion pulse |
| err | output | NUM_CORES | One-cycle standby timeout pulse |

## Verification
The bench targets standby arriving late, arriving at once, and never arriving. A design that counts the wait wrongly would reset a core that never went idle, or give up one cycle early. It checks the exact cycle the clamps drop and the exact hold length, where an off-by-one shows as 4 or 6 clamped cycles, or 15 or 17 reset cycles. It holds a second request while cores are busy, so a design that ignores back-pressure would restart a running sequence. Vector-only and combined modes are mixed to catch a vector reset that releases apart from the core reset or that touches the clamps.

// File: rtl/soft_rst_pkg.sv
package soft_rst_pkg;
  typedef enum logic [2:0] {
    SRS_IDLE      = 3'd0,
    SRS_WAIT_STBY = 3'd1,
    SRS_ASSERT    = 3'd2,
    SRS_CLAMP_REL = 3'd3,
    SRS_RELEASE   = 3'd4
  } srs_state_e;
endpackage

// File: rtl/srs_req_intake.sv
module srs_req_intake #(
  parameter int NUM_CORES = 4
) (
  input  logic                 req_valid,
  input  logic [NUM_CORES-1:0] req_mask,
  input  logic [NUM_CORES-1:0] busy,
  output logic                 req_ready,
  output logic [NUM_CORES-1:0] start
);
  logic accept;

  assign req_ready = ~|busy;
  assign accept    = req_valid & req_ready;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_start
    assign start[g] = accept & req_mask[g];
  end
endmodule

// File: rtl/srs_core_fsm.sv
module srs_core_fsm
  import soft_rst_pkg::*;
#(
  parameter int CLAMP_DLY = 5,
  parameter int MIN_HOLD  = 16,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_vec_only,
  input  logic             start_with_vec,
  input  logic             standby_idle,
  input  logic [TMO_W-1:0] timeout_cycles,
  output logic             core_rst_n,
  output logic             vec_rst_n,
  output logic             clamp_en,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int HOLD_W = $clog2(MIN_HOLD + 1);
  localparam logic [HOLD_W-1:0] CLAMP_LAST = HOLD_W'(CLAMP_DLY - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST  = HOLD_W'(MIN_HOLD - 1);

  srs_state_e        st;
  logic [HOLD_W-1:0] hold_cnt;
  logic [TMO_W-1:0]  wait_cnt;
  logic [TMO_W:0]    wait_next;
  logic              vonly_q, wvec_q, err_q, in_reset;

  assign wait_next = {1'b0, wait_cnt} + (TMO_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SRS_IDLE;
      hold_cnt <= '0;
      wait_cnt <= '0;
      vonly_q  <= 1'b0;
      wvec_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st)
        SRS_IDLE: begin
          if (start) begin
            vonly_q  <= start_vec_only;
            wvec_q   <= start_with_vec;
            hold_cnt <= '0;
            wait_cnt <= '0;
            st       <= start_vec_only ? SRS_ASSERT : SRS_WAIT_STBY;
          end
        end
        SRS_WAIT_STBY: begin
          if (standby_idle) begin
            hold_cnt <= '0;
            st       <= SRS_ASSERT;
          end else if (wait_next >= {1'b0, timeout_cycles}) begin
            err_q <= 1'b1;
            st    <= SRS_IDLE;
          end else begin
            wait_cnt <= wait_cnt + TMO_W'(1);
          end
        end
        SRS_ASSERT: begin
          hold_cnt <= hold_cnt + HOLD_W'(1);
          if (hold_cnt == CLAMP_LAST) st <= SRS_CLAMP_REL;
        end
        SRS_CLAMP_REL: begin
          hold_cnt <= hold_cnt + HOLD_W'(1);
          if (hold_cnt == HOLD_LAST) st <= SRS_RELEASE;
        end
        SRS_RELEASE: st <= SRS_IDLE;
        default:     st <= SRS_IDLE;
      endcase
    end
  end

  assign in_reset   = (st == SRS_ASSERT) || (st == SRS_CLAMP_REL);
  assign core_rst_n = ~(in_reset & ~vonly_q);
  assign vec_rst_n  = ~(in_reset & (vonly_q | wvec_q));
  assign clamp_en   = ~vonly_q & ((st == SRS_WAIT_STBY) || (st == SRS_ASSERT));
  assign busy       = (st != SRS_IDLE);
  assign done       = (st == SRS_RELEASE);
  assign err        = err_q;
endmodule

// File: rtl/soft_rst_seq.sv
module soft_rst_seq #(
  parameter int NUM_CORES = 4,
  parameter int CLAMP_DLY = 5,
  parameter int MIN_HOLD  = 16,
  parameter int TMO_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [NUM_CORES-1:0] req_mask,
  input  logic                 req_vec_only,
  input  logic                 req_with_vec,
  input  logic [TMO_W-1:0]     timeout_cycles,
  input  logic [NUM_CORES-1:0] standby_idle,
  output logic [NUM_CORES-1:0] core_rst_n,
  output logic [NUM_CORES-1:0] vec_rst_n,
  output logic [NUM_CORES-1:0] clamp_en,
  output logic [NUM_CORES-1:0] busy,
  output logic [NUM_CORES-1:0] done,
  output logic [NUM_CORES-1:0] err
);
  logic [NUM_CORES-1:0] start;

  srs_req_intake #(.NUM_CORES(NUM_CORES)) u_intake (
    .req_valid (req_valid),
    .req_mask  (req_mask),
    .busy      (busy),
    .req_ready (req_ready),
    .start     (start)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    srs_core_fsm #(
      .CLAMP_DLY (CLAMP_DLY),
      .MIN_HOLD  (MIN_HOLD),
      .TMO_W     (TMO_W)
    ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start[g]),
      .start_vec_only (req_vec_only),
      .start_with_vec (req_with_vec),
      .standby_idle   (standby_idle[g]),
      .timeout_cycles (timeout_cycles),
      .core_rst_n     (core_rst_n[g]),
      .vec_rst_n      (vec_rst_n[g]),
      .clamp_en       (clamp_en[g]),
      .busy           (busy[g]),
      .done           (done[g]),
      .err            (err[g])
    );
  end
endmodule

// File: rtl/soft_rst_seq_chk.sv
module soft_rst_seq_chk #(
  parameter int NUM_CORES = 4,
  parameter int CLAMP_DLY = 5,
  parameter int MIN_HOLD  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] standby_idle,
  input logic [NUM_CORES-1:0] core_rst_n,
  input logic [NUM_CORES-1:0] vec_rst_n,
  input logic [NUM_CORES-1:0] clamp_en,
  input logic [NUM_CORES-1:0] done,
  input logic [NUM_CORES-1:0] err
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    logic [15:0] low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_cnt <= '0;
      else if (core_rst_n[g]) low_cnt <= '0;
      else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
    end

    assert_reset_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_n[g]) |-> $past(standby_idle[g]));
    assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err[g] |=> !err[g]);
    assert_clamp_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst_n[g] && (low_cnt < 16'(CLAMP_DLY))) |-> clamp_en[g]);
    assert_clamp_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst_n[g] && (low_cnt >= 16'(CLAMP_DLY))) |-> !clamp_en[g]);
    assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n[g]) |-> (low_cnt >= 16'(MIN_HOLD)));
    assert_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst_n[g] && !vec_rst_n[g]) |=> (core_rst_n[g] == vec_rst_n[g]));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done[g] |=> !done[g]);
    assert_done_not_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done[g] && err[g]));
  end
endmodule

bind soft_rst_seq soft_rst_seq_chk #(
  .NUM_CORES (NUM_CORES),
  .CLAMP_DLY (CLAMP_DLY),
  .MIN_HOLD  (MIN_HOLD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby_idle (standby_idle),
  .core_rst_n   (core_rst_n),
  .vec_rst_n    (vec_rst_n),
  .clamp_en     (clamp_en),
  .done         (done),
  .err          (err)
);

// File: tb/soft_rst_seq_bench.sv
`timescale 1ns/1ps
module soft_rst_seq_bench;
  localparam int N = 4;
  localparam int TW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_vec_only = 0, req_with_vec = 0;
  logic [N-1:0] req_mask = '0, standby_idle = '0;
  logic [TW-1:0] timeout_cycles = 8'd12;
  logic req_ready;
  logic [N-1:0] core_rst_n, vec_rst_n, clamp_en, busy, done, err;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  soft_rst_seq u_soft_rst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_vec_only(req_vec_only), .req_with_vec(req_with_vec),
    .timeout_cycles(timeout_cycles), .standby_idle(standby_idle),
    .core_rst_n(core_rst_n), .vec_rst_n(vec_rst_n), .clamp_en(clamp_en),
    .busy(busy), .done(done), .err(err)
  );

  // Behavioural reference: phase 0 idle, 1 waiting, 2 in reset, 3 done cycle
  int ph[N], waited[N], lowc[N];
  bit vo[N], wv[N], ef[N];
  bit rdy_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ph[i] = 0; waited[i] = 0; lowc[i] = 0; vo[i] = 0; wv[i] = 0; ef[i] = 0;
      end
    end else begin
      rdy_m = 1;
      for (int i = 0; i < N; i++) if (ph[i] != 0) rdy_m = 0;
      for (int i = 0; i < N; i++) begin
        ef[i] = 0;
        case (ph[i])
          0: if (req_valid && rdy_m && req_mask[i]) begin
               vo[i] = req_vec_only; wv[i] = req_with_vec; lowc[i] = 0; waited[i] = 0;
               ph[i] = req_vec_only ? 2 : 1;
             end
          1: if (standby_idle[i]) begin ph[i] = 2; lowc[i] = 0; end
             else if (waited[i] + 1 >= int'(timeout_cycles)) begin ph[i] = 0; ef[i] = 1; end
             else waited[i]++;
          2: begin lowc[i]++; if (lowc[i] == 16) ph[i] = 3; end
          default: ph[i] = 0;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit er;
      er = 1;
      for (int i = 0; i < N; i++) begin
        bit e_core, e_vec, e_clamp;
        if (ph[i] != 0) er = 0;
        e_core  = !(ph[i] == 2 && !vo[i]);
        e_vec   = !(ph[i] == 2 && (vo[i] || wv[i]));
        e_clamp = (ph[i] == 1) || (ph[i] == 2 && !vo[i] && lowc[i] < 5);
        chk(core_rst_n[i] == e_core, "R2,R5", $sformatf("core_rst_n[%0d]", i), core_rst_n[i], e_core);
        chk(vec_rst_n[i] == e_vec, "R6,R7", $sformatf("vec_rst_n[%0d]", i), vec_rst_n[i], e_vec);
        chk(clamp_en[i] == e_clamp, "R4", $sformatf("clamp_en[%0d]", i), clamp_en[i], e_clamp);
        chk(busy[i] == (ph[i] != 0), "R2", $sformatf("busy[%0d]", i), busy[i], ph[i] != 0);
        chk(done[i] == (ph[i] == 3), "R8", $sformatf("done[%0d]", i), done[i], ph[i] == 3);
        chk(err[i] == ef[i], "R3", $sformatf("err[%0d]", i), err[i], ef[i]);
      end
      chk(req_ready == er, "R1", "req_ready", req_ready, er);
    end
  end

  task automatic send(input logic [N-1:0] m, input logic vonly, input logic wvec);
    req_mask = m; req_vec_only = vonly; req_with_vec = wvec; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (busy != '0 && guard < 500);
    chk(busy == '0, "R1", "idle after sequence", busy, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(core_rst_n == '1, "R10", "core_rst_n in reset", core_rst_n, 15);
    chk(vec_rst_n == '1, "R10", "vec_rst_n in reset", vec_rst_n, 15);
    chk(clamp_en == '0 && busy == '0 && done == '0 && err == '0, "R10", "status in reset",
        {clamp_en, busy, done, err}, 0);
    chk(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // Core 0, standby already high, no vector reset
    standby_idle = 4'b0001;
    send(4'b0001, 0, 0);
    repeat (6) @(negedge clk);
    chk(core_rst_n[3:1] == 3'b111 && busy[3:1] == 3'b000, "R9", "unmasked cores",
        {core_rst_n[3:1], busy[3:1]}, 56);
    wait_idle();

    // Core 1 with vector reset, standby arrives late
    standby_idle = 4'b0000;
    send(4'b0010, 0, 1);
    repeat (4) @(negedge clk);
    standby_idle[1] = 1;
    wait_idle();

    // Core 2 never goes idle: timeout
    standby_idle = 4'b0000;
    timeout_cycles = 8'd8;
    send(4'b0100, 0, 1);
    wait_idle();

    // Timeout value 0 acts as 1
    timeout_cycles = 8'd0;
    send(4'b1000, 0, 0);
    wait_idle();
    timeout_cycles = 8'd12;

    // Vector-only on cores 0 and 3, standby low
    send(4'b1001, 1, 0);
    wait_idle();

    // All cores, staggered standby, with a second request held back
    standby_idle = 4'b0000;
    send(4'b1111, 0, 1);
    fork
      begin
        for (int k = 0; k < N; k++) begin
          repeat (2) @(negedge clk);
          standby_idle[k] = 1;
        end
      end
      begin
        send(4'b0110, 1, 0);
      end
    join
    chk(1'b1, "R1", "held request taken", 1, 1);
    wait_idle();

    // Empty mask
    send(4'b0000, 0, 1);
    repeat (3) @(negedge clk);
    chk(busy == '0 && core_rst_n == '1 && vec_rst_n == '1, "R9", "empty mask no effect",
        {busy, core_rst_n, vec_rst_n}, 255);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule